// File: doc/BRIEF.md
# Framebuffer Control and Status Registers with End-of-Frame Interrupt

This block is the upper half of a 32-byte register window for a framebuffer controller. It holds a control byte, a status byte and fourteen general byte registers that software uses for cursor and video-timing values. The lower sixteen offsets belong to a palette unit elsewhere. Here they read as zero and swallow writes.

A one-cycle end-of-frame pulse comes in from the video timing logic. When the interrupt-enable bit of the control byte is set, the pulse latches a sticky pending flag, and a level interrupt output follows that flag. Software reads the status byte to see the pending flag, merged with fixed monitor-identification and colour-board bits. It writes the status byte with any value to acknowledge the interrupt.

The bus is a simple byte-wide strobe interface. A read strobe captures the addressed byte into a registered read-data output at the next clock edge. A write strobe updates the addressed byte at the next clock edge. The asynchronous active-low reset is released synchronously inside the block.

Top module: `fbctl_regs`

## Requirements
- R1: After reset, irq_o is 0, bus_rdata is 0x00, control (offset 0x10) reads 0x00, status (offset 0x11) reads 0x61, and every general register reads 0x00.
- R2: Control at offset 0x10 reads back exactly the last byte written to it. Its bit 7 is the interrupt enable.
- R3: Offsets 0x12 through 0x1F are fourteen independent read/write byte registers.
- R4: An end-of-frame pulse sampled while control bit 7 is 1 sets the pending flag. Status then reads 0xE1 (bit 7 pending, bits 6:5 = 11 monitor ID, bit 0 = 1 colour board, other bits 0). irq_o rises one clock after the pending flag is set.
- R5: An end-of-frame pulse sampled while control bit 7 is 0 has no effect: status stays 0x61 and irq_o stays 0.
- R6: A write of any value to offset 0x11 clears a set pending flag, and irq_o falls one clock later. A status write never changes the identification bits.
- R7: If an end-of-frame pulse with interrupts enabled and a status write fall in the same cycle, the pending flag stays set and irq_o stays 1.
- R8: Reads of offsets 0x00 through 0x0F return 0x00. Writes to them change no register in the block.
- R9: bus_rdata is loaded with the addressed byte at the clock edge that samples bus_rd, and it holds that value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions take the end-of-frame input to be a single-cycle pulse that is sampled like any other synchronous input. They also take a simultaneous read and write to the same offset to be legal, with the read returning the old value. The stimulus drives every strobe and pulse for exactly one cycle, away from the clock edge. It does not change control in the same cycle as a pulse, so each pending-flag outcome depends only on a settled enable bit. The collision cases of R7 are produced on purpose by raising the status write and the pulse together.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;
  // Offsets inside the upper half of the window (low nibble)
  localparam logic [3:0] CTRL_SLOT  = 4'h0;
  localparam logic [3:0] STAT_SLOT  = 4'h1;
  localparam logic [3:0] STORE_SLOT = 4'h2;

  // Status bit layout
  localparam int unsigned PEND_BIT = 7;
  localparam int unsigned IEN_BIT  = 7;
  localparam logic [7:0] STAT_ID   = 8'h61;

  typedef struct packed {
    logic ctrl;
    logic stat;
    logic store;
  } fbctl_sel_t;
endpackage

// File: rtl/fbctl_rst_sync.sv
module fbctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fbctl_decode.sv
module fbctl_decode
  import fbctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output fbctl_sel_t        sel,
  output logic [IDX_W-1:0]  store_idx
);
  localparam int unsigned LOW_W = ADDR_W - 1;

  logic             upper;
  logic [LOW_W-1:0] slot;
  logic [LOW_W-1:0] slot_off;

  always_comb begin
    upper     = addr[ADDR_W-1];
    slot      = addr[LOW_W-1:0];
    slot_off  = slot - LOW_W'(STORE_SLOT);
    sel.ctrl  = upper && (slot == LOW_W'(CTRL_SLOT));
    sel.stat  = upper && (slot == LOW_W'(STAT_SLOT));
    sel.store = upper && (slot >= LOW_W'(STORE_SLOT));
    store_idx = IDX_W'(slot_off);
  end
endmodule

// File: rtl/fbctl_store.sv
module fbctl_store #(
  parameter int unsigned NUM    = 14,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] byte_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_byte
    logic              load;
    logic [DATA_W-1:0] byte_d;

    always_comb begin
      load   = wr_en && (idx == IDX_W'(g));
      byte_d = load ? wdata : byte_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[g] <= '0;
      end else if (load) begin
        byte_q[g] <= byte_d;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM; i++) begin
      if (idx == IDX_W'(i)) begin
        rdata = byte_q[i];
      end
    end
  end
endmodule

// File: rtl/fbctl_irq.sv
module fbctl_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic irq_en,
  input  logic ack,
  output logic pend_q,
  output logic irq_q
);
  logic pend_d;
  logic set_ev;

  always_comb begin
    set_ev = frame_end && irq_en;
    pend_d = pend_q;
    if (set_ev) begin
      pend_d = 1'b1;
    end else if (ack) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= pend_q;
    end
  end
endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
  import fbctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_end,
  output logic              irq_o
);
  localparam int unsigned NUM_STORE = (2 ** (ADDR_W - 1)) - int'(STORE_SLOT);
  localparam int unsigned IDX_W     = $clog2(NUM_STORE);

  logic              rst_sync_n;
  fbctl_sel_t        sel;
  logic [IDX_W-1:0]  store_idx;
  logic [DATA_W-1:0] store_rd;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ctrl_d;
  logic              ctrl_ld;
  logic              pend_q;
  logic              irq_q;
  logic              ack;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rdata_q;

  fbctl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fbctl_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr      (bus_addr),
    .sel       (sel),
    .store_idx (store_idx)
  );

  fbctl_store #(.NUM(NUM_STORE), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (bus_wr && sel.store),
    .idx   (store_idx),
    .wdata (bus_wdata),
    .rdata (store_rd)
  );

  fbctl_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .frame_end (frame_end),
    .irq_en    (ctrl_q[IEN_BIT]),
    .ack       (ack),
    .pend_q    (pend_q),
    .irq_q     (irq_q)
  );

  // Control register
  always_comb begin
    ctrl_ld = bus_wr && sel.ctrl;
    ctrl_d  = ctrl_ld ? bus_wdata : ctrl_q;
    ack     = bus_wr && sel.stat;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
    end else if (ctrl_ld) begin
      ctrl_q <= ctrl_d;
    end
  end

  // Read path
  always_comb begin
    rd_d = '0;
    if (sel.ctrl) begin
      rd_d = ctrl_q;
    end else if (sel.stat) begin
      rd_d = DATA_W'(STAT_ID);
      rd_d[PEND_BIT] = pend_q;
    end else if (sel.store) begin
      rd_d = store_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/fbctl_regs_chk.sv
module fbctl_regs_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              frame_end,
  input logic              irq_o,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              pend_q
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(17);

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_CTRL |=> ctrl_q == $past(bus_wdata)); // R2

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && ctrl_q[7] |=> pend_q); // R4

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |=> irq_o); // R4

  AST_NO_SET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q && !(frame_end && ctrl_q[7]) |=> !pend_q); // R5

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_STAT && !(frame_end && ctrl_q[7]) |=> !pend_q); // R6

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |=> !irq_o); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_STAT && frame_end && ctrl_q[7] |=> pend_q); // R7

  AST_STAT_ID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == A_STAT |=> (bus_rdata & 8'h7F) == 8'h61); // R4

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_addr[ADDR_W-1] |=> bus_rdata == '0); // R8

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R9
endmodule

bind fbctl_regs fbctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .frame_end (frame_end),
  .irq_o     (irq_o),
  .ctrl_q    (ctrl_q),
  .pend_q    (pend_q)
);

// File: tb/fbctl_regs_tb.sv
module fbctl_regs_tb;
  logic       clk;
  logic       rst_n;
  logic       bus_wr;
  logic       bus_rd;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       frame_end;
  logic       irq_o;

  int n_chk;
  int n_fail;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pend;

  fbctl_regs u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .frame_end (frame_end),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Monitor: a read sampled at an edge is compared at the following falling edge
  always @(posedge clk) rd_pend <= bus_rd;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL scoreboard: unexpected read result %02h", bus_rdata);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic do_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_eof();
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s: irq_o actual %0b expected %0b", t, irq_o, e);
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    drain();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    bus_wdata = '0; frame_end = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1");
    n_chk++;
    if (bus_rdata !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: rdata actual %02h expected 00", bus_rdata);
    end
    do_read(5'h10, 8'h00, "R1 ctrl");
    do_read(5'h11, 8'h61, "R1 status");
    do_read(5'h12, 8'h00, "R1 store");
    do_read(5'h1F, 8'h00, "R1 store");

    // R2 control readback
    do_write(5'h10, 8'h5A);
    do_read(5'h10, 8'h5A, "R2");
    do_write(5'h10, 8'h7F);
    do_read(5'h10, 8'h7F, "R2");

    // R3 general registers
    for (int i = 2; i < 16; i++) do_write(5'(16 + i), 8'(i * 17 + 3));
    for (int i = 2; i < 16; i++) do_read(5'(16 + i), 8'(i * 17 + 3), "R3");

    // R5 pulse with interrupts disabled (ctrl = 0x7F, bit 7 clear)
    pulse_eof();
    chk_irq(1'b0, "R5");
    @(negedge clk);
    chk_irq(1'b0, "R5");
    do_read(5'h11, 8'h61, "R5");

    // R4 pulse with interrupts enabled
    do_write(5'h10, 8'h80);
    pulse_eof();
    chk_irq(1'b0, "R4 lag");
    @(negedge clk);
    chk_irq(1'b1, "R4");
    do_read(5'h11, 8'hE1, "R4");
    pulse_eof();
    chk_irq(1'b1, "R4 repeat");

    // R6 acknowledge
    do_write(5'h11, 8'h00);
    chk_irq(1'b1, "R6 lag");
    @(negedge clk);
    chk_irq(1'b0, "R6");
    do_read(5'h11, 8'h61, "R6");
    do_write(5'h11, 8'hFF);
    do_read(5'h11, 8'h61, "R6 idle");
    chk_irq(1'b0, "R6 idle");

    // R7 collision, from pending set
    pulse_eof();
    @(negedge clk);
    chk_irq(1'b1, "R7 setup");
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h11; bus_wdata = 8'h80; frame_end = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; frame_end = 1'b0;
    chk_irq(1'b1, "R7");
    @(negedge clk);
    chk_irq(1'b1, "R7");
    do_read(5'h11, 8'hE1, "R7");
    // R7 collision, from pending clear
    do_write(5'h11, 8'h00);
    @(negedge clk);
    chk_irq(1'b0, "R7 clear");
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h11; bus_wdata = 8'h00; frame_end = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; frame_end = 1'b0;
    @(negedge clk);
    chk_irq(1'b1, "R7 idle");
    do_write(5'h11, 8'h00);

    // R8 low offsets
    for (int i = 0; i < 16; i++) do_write(5'(i), 8'hFF);
    for (int i = 0; i < 16; i++) do_read(5'(i), 8'h00, "R8");
    do_read(5'h10, 8'h80, "R8 ctrl");
    do_read(5'h11, 8'h61, "R8 status");
    for (int i = 2; i < 16; i++) do_read(5'(16 + i), 8'(i * 17 + 3), "R8 store");

    // R9 hold while read strobe low
    do_read(5'h14, 8'(4 * 17 + 3), "R9");
    drain();
    do_write(5'h14, 8'h00);
    bus_addr = 5'h11;
    repeat (2) @(negedge clk);
    n_chk++;
    if (bus_rdata !== 8'(4 * 17 + 3)) begin
      n_fail++;
      $display("FAIL R9: rdata actual %02h expected %02h", bus_rdata, 8'(4 * 17 + 3));
    end

    finish_run();
  end
endmodule